// File: doc/BRIEF.md
# Recurrent Spiking Reservoir with Membrane Snapshots

This block is a small recurrent network of eight leaky integrate-and-fire neurons. The neurons sit in three layers of three, two and three. Each neuron has two synapses and all eight update together on every time step. A synapse needs no multiplier. It compares its stored four-bit weight with a value from one shared pseudo-random generator, and the spike it carries then adds or removes a fixed charge quantum. The spikes a neuron fires are held in a register for one step and then drive the synapses of other neurons. External spike trains drive the remaining synapses.

A presentation begins with a start pulse, which clears the network. Each asserted step strobe then advances the network by one time step. After every fiftieth step the block copies all eight membrane potentials into a 40-entry snapshot buffer. After step 250 it raises a done flag and ignores further steps. An offline classifier then reads the buffer by address.

Top module: `spike_reservoir`

## Requirements
- R1: After reset, and in the cycle after a start pulse (start has priority over step_en), all membranes are 0, all spikes are 0, the step position is 0, every buffer entry reads 0, done is 0 and the random register holds 6'b000001.
- R2: State changes only in a cycle with step_en high and done low. In any other cycle the spikes, the membranes, the random register and the buffer hold their values.
- R3: The random register is 6 bits wide. On each step it becomes {q[4:0], q[5]^q[4]}. Every synapse in a step uses the low nibble q[3:0] as it was before that step.
- R4: Synapse s of neuron n uses weight WEIGHTS[4*(2n+s)+:4]. When its source spike is 1, it adds +512 (1/8 in a Q.12 membrane) if weight > q[3:0], and -512 otherwise. When its source spike is 0, it adds nothing.
- R5: The candidate potential is V - ((V - 4) >>> 3) plus the sum of both synapse terms, using an arithmetic shift. A negative candidate is clamped to 0.
- R6: When the candidate is 614 or more, the neuron fires. Its spike output is 1 for that step and V becomes 4. Otherwise the spike is 0 and V takes the candidate value.
- R7: Synapse sources are listed below. ext[k] is an external input and nK is the spike of neuron K from the previous step. n0: ext0,n5. n1: ext1,n6. n2: ext2,n7. n3: n0,n1. n4: n1,n2. n5: n3,ext3. n6: n3,n4. n7: n4,ext4.
- R8: After step 50j (j = 1 to 5), buffer entry 8(j-1)+n holds the potential of neuron n that results from that step.
- R9: done rises together with the capture of step 250. It then stays high until a start pulse, and step strobes have no effect while it is high.
- R10: A read address of 40 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the network before a new presentation |
| step_en | input | 1 | Advances the network by one time step |
| ext_spk | input | 5 | External spike inputs for this step |
| rd_addr | input | 6 | Snapshot buffer read address |
| rd_data | output | 18 | Snapshot entry at rd_addr (unsigned Q6.12) |
| spikes | output | 8 | Spikes fired by each neuron in the latest step |
| done | output | 1 | All five snapshots have been captured |

## Verification
A fault in the synapse terms, the leak or the random register changes which neurons fire. It therefore shows on the spike outputs within a few steps, and the recurrent wiring spreads it to the other layers. A fault in the wiring or in the one-step feedback delay reaches spikes one step after the source neuron first fires. An error in the step position or the slot index shows only at the capture points and at done, so the bench compares all 40 buffer entries, and the done flag after step 249 and after step 250.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   localparam int N_NEUR = 8;
   localparam int N_SYN  = 2;
   localparam int N_EXT  = 5;
   localparam int N_SRC  = N_NEUR + N_EXT;
   // Source code per synapse (index 2*neuron + synapse).
   // Codes 0..7 select a delayed neuron spike; 8+k selects external input k.
   localparam int SRC_TAB [N_NEUR*N_SYN] = '{
      8, 5,   9, 6,   10, 7,
      0, 1,   1, 2,
      3, 11,  3, 4,   4, 12 };
endpackage

// File: rtl/rsv_lfsr.sv
module rsv_lfsr #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [WIDTH-1:0] state
);
   logic fb;

   generate
      if (WIDTH == 4) begin : g_t4
         assign fb = state[3] ^ state[2];
      end else if (WIDTH == 5) begin : g_t5
         assign fb = state[4] ^ state[2];
      end else if (WIDTH == 6) begin : g_t6
         assign fb = state[5] ^ state[4];
      end else if (WIDTH == 7) begin : g_t7
         assign fb = state[6] ^ state[5];
      end else if (WIDTH == 8) begin : g_t8
         assign fb = state[7] ^ state[5] ^ state[4] ^ state[3];
      end else begin : g_bad
         $error("rsv_lfsr: WIDTH must be 4 to 8");
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state <= WIDTH'(1);
      else if (clr)   state <= WIDTH'(1);
      else if (adv)   state <= {state[WIDTH-2:0], fb};
   end

   // R3: a maximal-length register never reaches the all-zero lock state
   a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
   // R2: no advance, no change
   a_r2_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(state));
endmodule

// File: rtl/rsv_neuron.sv
module rsv_neuron #(
   parameter int MEM_W   = 18,
   parameter int FRAC    = 12,
   parameter int W_W     = 4,
   parameter int INC_SH  = 3,
   parameter int LEAK_SH = 3,
   parameter int TH_Q    = 614,
   parameter int VRST_Q  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               adv,
   input  logic [1:0]         syn_in,
   input  logic [2*W_W-1:0]   wts,
   input  logic [W_W-1:0]     rnd,
   output logic [MEM_W-1:0]   mem,
   output logic [MEM_W-1:0]   mem_nxt,
   output logic               spk
);
   localparam int EW = MEM_W + 3;
   localparam logic signed [EW-1:0] VRST_X = EW'(VRST_Q);
   localparam logic signed [EW-1:0] TH_X   = EW'(TH_Q);
   localparam logic signed [EW-1:0] INC_X  = EW'(1) <<< (FRAC - INC_SH);

   logic signed [EW-1:0] term [2];
   logic signed [EW-1:0] m_x, leak, cand, cand_c;
   logic                 fire;

   generate
      for (genvar s = 0; s < 2; s++) begin : g_syn
         always_comb begin
            if (!syn_in[s])                        term[s] = '0;
            else if (wts[s*W_W +: W_W] > rnd)      term[s] = INC_X;
            else                                   term[s] = -INC_X;
         end
      end
   endgenerate

   always_comb begin
      m_x    = signed'(EW'(mem));
      leak   = (m_x - VRST_X) >>> LEAK_SH;
      cand   = m_x - leak + term[0] + term[1];
      cand_c = cand[EW-1] ? '0 : cand;
      fire   = (cand_c >= TH_X);
      mem_nxt = fire ? MEM_W'(VRST_Q) : cand_c[MEM_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
         spk <= 1'b0;
      end else if (clr) begin
         mem <= '0;
         spk <= 1'b0;
      end else if (adv) begin
         mem <= mem_nxt;
         spk <= fire;
      end
   end

   // R6: firing resets, so a stored potential is always below threshold
   a_r6_below_th: assert property (@(posedge clk) disable iff (!rst_n)
      mem < MEM_W'(TH_Q));
   // R6: a spike in a step leaves the membrane at the reset level
   a_r6_fire_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && fire) |=> (spk && mem == MEM_W'(VRST_Q)));
   // R2: membrane holds between steps
   a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> ($stable(mem) && $stable(spk)));
endmodule

// File: rtl/rsv_snap.sv
module rsv_snap #(
   parameter int MEM_W  = 18,
   parameter int N      = 8,
   parameter int GAP    = 50,
   parameter int NUM    = 5,
   parameter int ADDR_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               adv,
   input  logic [N*MEM_W-1:0] mem_nxt,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [MEM_W-1:0]   rd_data,
   output logic               done
);
   localparam int DEPTH = N * NUM;
   localparam int PH_W  = $clog2(GAP);
   localparam int SL_W  = $clog2(NUM + 1);

   logic [PH_W-1:0]  ph;
   logic [SL_W-1:0]  slot;
   logic [MEM_W-1:0] buf_q [DEPTH];
   logic             last_ph;

   assign last_ph = (ph == PH_W'(GAP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         ph   <= '0;
         slot <= '0;
         done <= 1'b0;
         for (int e = 0; e < DEPTH; e++) buf_q[e] <= '0;
      end else if (adv && !done) begin
         if (last_ph) begin
            ph   <= '0;
            slot <= slot + 1'b1;
            if (slot == SL_W'(NUM - 1)) done <= 1'b1;
            for (int e = 0; e < DEPTH; e++)
               if (SL_W'(e / N) == slot)
                  buf_q[e] <= mem_nxt[(e % N)*MEM_W +: MEM_W];
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int e = 0; e < DEPTH; e++)
         if (rd_addr == ADDR_W'(e)) rd_data = buf_q[e];
   end

   // R9: done means every slot has been written
   a_r9_done_full: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (slot == SL_W'(NUM) && ph == '0));
   // R9: done holds until a clear
   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done);
   // R8: phase stays inside one capture interval
   a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      ph < PH_W'(GAP));
   // R2: step position holds without a step
   a_r2_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> ($stable(ph) && $stable(slot)));
endmodule

// File: rtl/spike_reservoir.sv
module spike_reservoir import rsv_pkg::*; #(
   parameter int MEM_W    = 18,
   parameter int FRAC     = 12,
   parameter int W_W      = 4,
   parameter int LFSR_W   = 6,
   parameter int INC_SH   = 3,
   parameter int LEAK_SH  = 3,
   parameter int TH_Q     = 614,
   parameter int VRST_Q   = 4,
   parameter int SNAP_GAP = 50,
   parameter int SNAP_NUM = 5,
   parameter logic [N_NEUR*N_SYN*W_W-1:0] WEIGHTS = 64'hC9A7_5BE3_8D6F_4A9C
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   start,
   input  logic                                   step_en,
   input  logic [N_EXT-1:0]                       ext_spk,
   input  logic [$clog2(SNAP_NUM*N_NEUR)-1:0]     rd_addr,
   output logic [MEM_W-1:0]                       rd_data,
   output logic [N_NEUR-1:0]                      spikes,
   output logic                                   done
);
   localparam int ADDR_W = $clog2(SNAP_NUM * N_NEUR);

   if (W_W > LFSR_W) begin : g_chk_w
      $error("spike_reservoir: weight width exceeds random width");
   end
   if (INC_SH > FRAC || TH_Q >= (1 << (MEM_W - 1))) begin : g_chk_q
      $error("spike_reservoir: fixed-point settings out of range");
   end
   if (SNAP_GAP < 2 || SNAP_NUM < 1) begin : g_chk_s
      $error("spike_reservoir: snapshot spacing or count invalid");
   end

   logic                     adv;
   logic [LFSR_W-1:0]        rq;
   logic [N_SRC-1:0]         src_all;
   logic [N_NEUR*MEM_W-1:0]  nxt_all;

   assign adv     = step_en && !done;
   assign src_all = {ext_spk, spikes};

   rsv_lfsr #(.WIDTH(LFSR_W)) u_rng (
      .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv), .state(rq));

   generate
      for (genvar n = 0; n < N_NEUR; n++) begin : g_neur
         logic [MEM_W-1:0] mem_q;
         logic [1:0]       sin;
         for (genvar s = 0; s < N_SYN; s++) begin : g_src
            assign sin[s] = src_all[SRC_TAB[n*N_SYN + s]];
         end
         rsv_neuron #(
            .MEM_W(MEM_W), .FRAC(FRAC), .W_W(W_W), .INC_SH(INC_SH),
            .LEAK_SH(LEAK_SH), .TH_Q(TH_Q), .VRST_Q(VRST_Q)
         ) u_n (
            .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv),
            .syn_in(sin),
            .wts(WEIGHTS[n*N_SYN*W_W +: N_SYN*W_W]),
            .rnd(rq[W_W-1:0]),
            .mem(mem_q),
            .mem_nxt(nxt_all[n*MEM_W +: MEM_W]),
            .spk(spikes[n]));
      end
   endgenerate

   rsv_snap #(
      .MEM_W(MEM_W), .N(N_NEUR), .GAP(SNAP_GAP), .NUM(SNAP_NUM), .ADDR_W(ADDR_W)
   ) u_snap (
      .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv),
      .mem_nxt(nxt_all), .rd_addr(rd_addr), .rd_data(rd_data), .done(done));

   // R1: a start pulse leaves the network cleared
   a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (spikes == '0 && !done));
   // R9: strobes after completion leave the spikes frozen
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(spikes));
   // R10: out-of-range reads return zero
   a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr) >= SNAP_NUM*N_NEUR) |-> (rd_data == '0));
endmodule

// File: tb/tb_spike_reservoir.sv
module tb_spike_reservoir;
   localparam logic [63:0] BW = 64'hC9A7_5BE3_8D6F_4A9C;
   localparam int SRC [16] = '{8,5, 9,6, 10,7, 0,1, 1,2, 3,11, 3,4, 4,12};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        step_en = 1'b0;
   logic [4:0]  ext_spk = '0;
   logic [5:0]  rd_addr = '0;
   logic [17:0] rd_data;
   logic [7:0]  spikes;
   logic        done;

   int errors = 0;
   int checks = 0;

   // model state
   int vm [8];
   int sp [8];
   int bm [40];
   int lq, ph, slot, mdone;

   always #2 clk = ~clk;

   spike_reservoir #(.WEIGHTS(BW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
      .ext_spk(ext_spk), .rd_addr(rd_addr), .rd_data(rd_data),
      .spikes(spikes), .done(done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic m_clear();
      for (int n = 0; n < 8; n++) begin vm[n] = 0; sp[n] = 0; end
      for (int e = 0; e < 40; e++) bm[e] = 0;
      lq = 1; ph = 0; slot = 0; mdone = 0;
   endtask

   // Reference step built from R3..R9
   task automatic m_step(input logic [4:0] ext);
      int r, nsp [8], nvm [8];
      if (mdone) return;
      r = lq & 15;
      for (int n = 0; n < 8; n++) begin
         int sum, leak, cand;
         sum = 0;
         for (int s = 0; s < 2; s++) begin
            int code, w, b;
            code = SRC[n*2+s];
            b = (code < 8) ? sp[code] : int'(ext[code-8]);
            w = int'((BW >> (4*(n*2+s))) & 64'hF);
            if (b != 0) sum += (w > r) ? 512 : -512;
         end
         leak = (vm[n] - 4) >>> 3;
         cand = vm[n] - leak + sum;
         if (cand < 0) cand = 0;
         if (cand >= 614) begin nvm[n] = 4; nsp[n] = 1; end
         else begin nvm[n] = cand; nsp[n] = 0; end
      end
      for (int n = 0; n < 8; n++) begin vm[n] = nvm[n]; sp[n] = nsp[n]; end
      lq = ((lq << 1) & 63) | (((lq >> 5) ^ (lq >> 4)) & 1);
      ph++;
      if (ph == 50) begin
         ph = 0;
         for (int n = 0; n < 8; n++) bm[slot*8+n] = vm[n];
         slot++;
         if (slot == 5) mdone = 1;
      end
   endtask

   function automatic int m_spk();
      int v = 0;
      for (int n = 0; n < 8; n++) v |= sp[n] << n;
      return v;
   endfunction

   function automatic logic [4:0] pat(input int id, input int t);
      logic [4:0] p;
      for (int k = 0; k < 5; k++)
         p[k] = (id == 2) ? 1'b1 : (((t*(k+3) + id*7 + k) % 5) < 2);
      return p;
   endfunction

   task automatic dut_step(input logic [4:0] ext);
      @(negedge clk);
      step_en = 1'b1; ext_spk = ext;
      @(negedge clk);
      step_en = 1'b0;
      m_step(ext);
      // R3 R4 R5 R6 R7: spikes follow the reference after every step
      chk(spikes == 8'(m_spk()), "R3 R4 R5 R6 R7 spikes", int'(spikes), m_spk());
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      rd_addr = 6'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic t_reset();
      int v;
      chk(spikes == 0, "R1 reset spikes", int'(spikes), 0);
      chk(done == 0, "R1 reset done", int'(done), 0);
      rd(0, v);  chk(v == 0, "R1 reset buf0", v, 0);
      rd(39, v); chk(v == 0, "R1 reset buf39", v, 0);
   endtask

   task automatic t_oob();
      int v;
      for (int a = 40; a < 64; a += 5) begin
         rd(a, v);
         chk(v == 0, "R10 out-of-range read", v, 0);
      end
   endtask

   // Full presentation with an idle gap, done timing and buffer compare
   task automatic t_run(input int id);
      int v;
      for (int t = 1; t <= 250; t++) begin
         dut_step(pat(id, t));
         if (t == 30) begin
            logic [7:0] hold;
            hold = spikes;
            repeat (5) @(negedge clk);
            chk(spikes == hold, "R2 idle hold spikes", int'(spikes), int'(hold));
         end
         if (t == 249) chk(done == 0, "R9 done before step 250", int'(done), 0);
         if (t == 250) chk(done == 1, "R9 done after step 250", int'(done), 1);
      end
      for (int e = 0; e < 40; e++) begin
         rd(e, v);
         chk(v == bm[e], "R8 snapshot entry", v, bm[e]);
      end
   endtask

   task automatic t_after_done();
      logic [7:0] hold;
      int v;
      hold = spikes;
      for (int t = 0; t < 10; t++) begin
         @(negedge clk); step_en = 1'b1; ext_spk = 5'h1F;
         @(negedge clk); step_en = 1'b0;
      end
      chk(spikes == hold, "R9 steps ignored spikes", int'(spikes), int'(hold));
      chk(done == 1, "R9 done stays", int'(done), 1);
      rd(0, v);  chk(v == bm[0], "R9 buffer kept 0", v, bm[0]);
      rd(47 - 8, v); chk(v == bm[39], "R9 buffer kept 39", v, bm[39]);
   endtask

   task automatic t_start_mid();
      int v;
      m_clear();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int t = 1; t <= 73; t++) dut_step(pat(1, t));
      @(negedge clk); start = 1'b1; step_en = 1'b1; ext_spk = 5'h1F;
      @(negedge clk); start = 1'b0; step_en = 1'b0;
      m_clear();
      chk(spikes == 0, "R1 start clears spikes", int'(spikes), 0);
      chk(done == 0, "R1 start clears done", int'(done), 0);
      rd(3, v); chk(v == 0, "R1 start clears buffer", v, 0);
   endtask

   initial begin
      #(200000 * 4);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_oob();
      t_run(0);
      t_after_done();
      t_start_mid();
      t_run(2);
      t_start_mid();
      t_run(1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule